// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block produces the word address for each beat of a four-beat burst in the front end of a synchronous memory. On a rising clock edge where either of its two address strobes is low, it captures a starting address and clears its internal two-bit beat counter. The first access of the burst therefore uses the captured address unchanged. Each later edge where the advance input is low moves the counter forward by one beat, so the four beats run in a 3-1-1-1 pattern. When advance is high, the counter and the address stay where they are.

The upper address bits never change during a burst. The low two bits follow one of two beat orders, chosen by a static mode pin. In linear order the start value and the beat count are added modulo four, so the address wraps inside its aligned four-word block. In interleaved order the start value and the beat count are combined by XOR. All state sits in registers. The output address is derived from that state and from the mode pin, so a change of mode shows up in the same cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: On a rising edge with `ads_proc_n` low, `addr_out` becomes `addr_in` and `beat` becomes 0 after that edge.
- R2: On a rising edge with `ads_ctrl_n` low, `addr_out` becomes `addr_in` and `beat` becomes 0 after that edge.
- R3: A strobe takes priority over `adv_n`. A strobe in the middle of a burst restarts it at beat 0 with the newly captured address.
- R4: On an edge with both strobes high and `adv_n` low, `beat` steps by one modulo 4 (3 goes to 0). The upper address bits `addr_out[AW-1:2]` stay unchanged.
- R5: On an edge with both strobes high and `adv_n` high, `beat` and `addr_out` hold their values.
- R6: With `linear_mode` = 1, `addr_out[1:0]` equals (captured start low bits + `beat`) mod 4.
- R7: With `linear_mode` = 0, `addr_out[1:0]` equals the captured start low bits XOR `beat`.
- R8: On a rising edge with `rst` high (synchronous, active high), `beat` and the captured address clear to 0, so `addr_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ads_proc_n | input | 1 | Processor-side address strobe, active low |
| ads_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| linear_mode | input | 1 | Beat order: 1 = linear wrap, 0 = interleaved XOR |
| addr_in | input | AW | Starting word address, captured on a strobe |
| addr_out | output | AW | Current word address of the burst |
| beat | output | 2 | Current beat index, 0 to 3 |

## Verification
Strobe capture, counter steps, holds and reset all take effect one rising edge after the inputs that cause them. The mode pin acts on `addr_out[1:0]` within the same cycle. The bench sets inputs on the falling edge and updates its own reference model when it waits for the rising edge. It compares `addr_out` and `beat` at the next falling edge, so every result is read half a period after the edge that produces it. This lets a change of mode be checked within its own cycle, against the model's current state.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // Low address bits for a given start offset and beat count.
  function automatic beat_t order_low(input beat_t start_lo, input beat_t cnt, input logic lin);
    beat_t sum;
    sum = start_lo + cnt;
    return lin ? sum : (start_lo ^ cnt);
  endfunction
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  restart,
  input  logic  step,
  output beat_t cnt
);
  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (step)      cnt <= cnt + beat_t'(1);
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic [AW-1:0] base,
  input  beat_t         cnt,
  input  logic          lin,
  output logic [AW-1:0] addr
);
  always_comb begin
    addr = base;
    addr[BEAT_W-1:0] = order_low(base[BEAT_W-1:0], cnt, lin);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ads_proc_n,
  input  logic          ads_ctrl_n,
  input  logic          adv_n,
  input  logic          linear_mode,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    beat
);
  logic          strobe;
  logic [AW-1:0] base_q;
  beat_t         cnt_q;

  assign strobe = ~ads_proc_n | ~ads_ctrl_n;

  burst_start_reg #(.AW(AW)) u_start (
    .clk(clk), .rst(rst), .load(strobe), .d(addr_in), .q(base_q)
  );

  burst_beat_ctr u_ctr (
    .clk(clk), .rst(rst), .restart(strobe), .step(~adv_n), .cnt(cnt_q)
  );

  burst_order_map #(.AW(AW)) u_map (
    .base(base_q), .cnt(cnt_q), .lin(linear_mode), .addr(addr_out)
  );

  assign beat = cnt_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          ads_proc_n,
  input logic          ads_ctrl_n,
  input logic          adv_n,
  input logic          linear_mode,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic [1:0]    beat
);
  logic idle;
  assign idle = ads_proc_n && ads_ctrl_n;

  assert_capture_R1_R2_R3: assert property (@(posedge clk) disable iff (rst)
    !idle |=> (beat == 2'd0) && (addr_out[AW-1:2] == $past(addr_in[AW-1:2])));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (idle && !adv_n) |=> (beat == $past(beat) + 2'd1) && $stable(addr_out[AW-1:2]));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (idle && adv_n) |=> $stable(beat) && $stable(addr_out[AW-1:2]));

  assert_linear_R6: assert property (@(posedge clk) disable iff (rst)
    (idle && !adv_n && linear_mode) |=>
      (!linear_mode || (addr_out[1:0] == $past(addr_out[1:0]) + 2'd1)));

  assert_xor_R7: assert property (@(posedge clk) disable iff (rst)
    (idle && !linear_mode) |=>
      (linear_mode || ((addr_out[1:0] ^ beat) == $past(addr_out[1:0] ^ beat))));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
  .adv_n(adv_n), .linear_mode(linear_mode), .addr_in(addr_in),
  .addr_out(addr_out), .beat(beat)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1, linear_mode = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;

  always #5 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
    .adv_n(adv_n), .linear_mode(linear_mode), .addr_in(addr_in),
    .addr_out(addr_out), .beat(beat)
  );

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input logic [1:0] c, input logic lin);
    logic [1:0] lo;
    lo = lin ? 2'(b[1:0] + c) : (b[1:0] ^ c);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(input string tag);
    logic [AW-1:0] ea;
    string mt;
    ea = exp_addr(m_base, m_cnt, linear_mode);
    mt = linear_mode ? "R6" : "R7";
    n_chk++;
    if (beat !== m_cnt) begin
      n_fail++;
      $display("FAIL %s beat: actual %0d expected %0d", tag, beat, m_cnt);
    end
    n_chk++;
    if (addr_out !== ea) begin
      n_fail++;
      $display("FAIL %s/%s addr: actual %h expected %h", tag, mt, addr_out, ea);
    end
  endtask

  // Drive at falling edge, update model through rising edge, check at next falling edge.
  task automatic cyc(input logic r, input logic pn, input logic cn, input logic an,
                     input logic lm, input logic [AW-1:0] a);
    string tag;
    rst = r; ads_proc_n = pn; ads_ctrl_n = cn; adv_n = an; linear_mode = lm; addr_in = a;
    if (r) begin m_base = '0; m_cnt = '0; tag = "R8"; end
    else if (!pn || !cn) begin
      m_base = a; m_cnt = '0;
      tag = !an ? "R3" : (!pn ? "R1" : "R2");
    end
    else if (!an) begin m_cnt = m_cnt + 2'd1; tag = "R4"; end
    else tag = "R5";
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R8: reset state
    cyc(1, 0, 1, 1, 1, 20'hABCDE);
    cyc(0, 1, 1, 1, 1, '0);
    // R1 + R6: linear from start offset 2 -> 2,3,0,1 then wraps to 2
    cyc(0, 0, 1, 1, 1, 20'h12346);
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 1, '0);
    // R5: hold
    cyc(0, 1, 1, 1, 1, 20'hFFFFF);
    cyc(0, 1, 1, 1, 1, 20'h00000);
    // R2 + R7: interleaved from offset 1 -> 1,0,3,2
    cyc(0, 1, 0, 1, 0, 20'h54321);
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, 0, '0);
    // R6/R7: mode switch mid-burst, same cycle
    cyc(0, 1, 1, 1, 1, '0);
    // R3: restart mid-burst while advancing
    cyc(0, 1, 0, 0, 1, 20'h0F00B);
    cyc(0, 1, 1, 0, 1, '0);
    cyc(0, 0, 0, 0, 0, 20'h0F00D);
    // R8: reset mid-burst
    cyc(0, 1, 1, 0, 0, '0);
    cyc(1, 1, 1, 0, 0, '0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic r, pn, cn, an, lm;
      r  = ($urandom % 50) == 0;
      pn = ($urandom % 6) != 0;
      cn = ($urandom % 6) != 0;
      an = ($urandom % 3) == 0;
      lm = ($urandom % 8) != 0 ? linear_mode : ~linear_mode;
      cyc(r, pn, cn, an, lm, AW'($urandom));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule